// File: doc/BRIEF.md
# Test Mode Entry Latch

This block decides when the overcharge protection logic runs in its accelerated test mode. A request flag, already qualified upstream by an analog margin comparison, must stay asserted for a set number of oscillator ticks before the block arms test mode. Once armed, the mode is latched, so the request may then be removed. While the mode is active, the detection-delay count handed to the debounce timer is swapped for a much shorter one. The release-delay and timer-reset-delay counts are also published by the block and do not change with the mode.

The latch leaves test mode on its own when the first overcharge detection count completes, which is signalled by a one-cycle done pulse. An undervoltage-lockout flag forces normal mode at any time and discards any partial entry progress. Requests are ignored while a detection count is running. Three delay grades are selectable on a two-bit input.

The controller has three states. ST_IDLE waits for a qualified request. ST_ARM counts ticks while the request stays qualified. ST_TEST is the latched test mode. The named transitions are: T_ARM (ST_IDLE to ST_ARM, qualified request seen), T_ABORT (ST_ARM to ST_IDLE, the request drops, a detection is busy, or lockout), T_ENTER (ST_ARM to ST_TEST, the tick that completes the hold count), T_DONE (ST_TEST to ST_IDLE, detection-done pulse) and T_UVLO (any state to ST_IDLE, lockout asserted).

Top module: `tmode_latch`

## Requirements
- R1: After reset test_mode is 0, and det_limit shows the normal value for the selected grade.
- R2: A qualified request is one with req=1, det_busy=0 and uvlo=0. It moves the block from ST_IDLE to ST_ARM on one clock edge. That edge counts no tick. After that, test_mode rises on the clock edge that carries the ENTRY_TICKS-th (default 80) tick seen while the request stays qualified. It is still 0 after ENTRY_TICKS-1 ticks.
- R3: If the request is dropped for even one cycle before entry, all progress is lost. A later entry needs a full ENTRY_TICKS ticks, counted again from the start.
- R4: Once test_mode is 1, it stays 1 while req is deasserted, for as long as no detection-done pulse and no lockout occurs.
- R5: While test_mode=1, det_limit depends on dly_sel. The value is 64 for dly_sel=0, 32 for 1, 88 for 2 and 64 for 3.
- R6: While test_mode=0, det_limit depends on dly_sel. The value is 4000 for dly_sel=0, 2000 for 1, 5650 for 2 and 4000 for 3.
- R7: A det_done pulse while test_mode=1 clears test_mode on that clock edge. The block returns to normal mode, and re-entry then needs a full new hold.
- R8: uvlo=1 clears test_mode on the next edge and aborts an entry that is in progress. Entry progress made before the lockout is not kept.
- R9: While det_busy=1 a request is ignored. No amount of ticks causes entry, and any entry in progress is aborted.
- R10: rel_limit and trst_limit are the same in both modes. For dly_sel 0 and 3 they are 64 and 12. For dly_sel 1 they are 2 and 12. For dly_sel 2 they are 88 and 17.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle oscillator tick, nominally one per millisecond |
| req | input | 1 | Test request: supply is above sense by the entry margin |
| det_busy | input | 1 | An overcharge detection count is in progress |
| det_done | input | 1 | One-cycle pulse when a detection count completes |
| uvlo | input | 1 | Undervoltage lockout active |
| dly_sel | input | 2 | Delay grade select |
| test_mode | output | 1 | Test mode active |
| det_limit | output | LIM_W | Detection-delay count in ticks for the current mode |
| rel_limit | output | LIM_W | Release-delay count in ticks (mode independent) |
| trst_limit | output | LIM_W | Timer-reset-delay count in ticks (mode independent) |

## Verification
The hardest case to reach from the ports is the exact entry boundary, together with loss of partial credit. Entry hides a tick counter with no visible output. The stimulus therefore spaces the ticks apart and starts each hold with a tick-free cycle. It then counts ticks out precisely and samples test_mode after ENTRY_TICKS-1 ticks and again after ENTRY_TICKS ticks. To prove that no progress survives, the same hold is cut short by a one-cycle request drop, by a lockout pulse or by a busy detection. After each cut, the bench shows that one tick fewer than a full count still leaves the mode off.

// File: rtl/tmode_pkg.sv
package tmode_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_TEST = 2'd2
    } tmode_state_e;

    typedef enum logic [1:0] {
        GRADE_STD   = 2'd0,
        GRADE_SHORT = 2'd1,
        GRADE_LONG  = 2'd2,
        GRADE_ALT   = 2'd3
    } tmode_grade_e;

endpackage

// File: rtl/tmode_hold_cnt.sv
// Counts qualified ticks during the arming phase; cleared whenever
// arming is not in progress so no partial credit survives.
module tmode_hold_cnt #(
    parameter int ENTRY_TICKS = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic last
);
    localparam int CW = (ENTRY_TICKS > 2) ? $clog2(ENTRY_TICKS) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(ENTRY_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (adv && (cnt_q != LAST_V)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign last = (cnt_q == LAST_V);
endmodule

// File: rtl/tmode_limits.sv
// Per-grade delay counts; only the detection delay depends on the mode.
module tmode_limits #(
    parameter int LIM_W  = 13,
    parameter int NORM_A = 4000,
    parameter int NORM_B = 2000,
    parameter int NORM_C = 5650,
    parameter int TEST_A = 64,
    parameter int TEST_B = 32,
    parameter int TEST_C = 88,
    parameter int REL_A  = 64,
    parameter int REL_B  = 2,
    parameter int REL_C  = 88,
    parameter int TRST_A = 12,
    parameter int TRST_B = 12,
    parameter int TRST_C = 17
) (
    input  logic [1:0]       sel,
    input  logic             fast,
    output logic [LIM_W-1:0] det,
    output logic [LIM_W-1:0] rel,
    output logic [LIM_W-1:0] trst
);
    import tmode_pkg::*;

    logic [LIM_W-1:0] norm_v;
    logic [LIM_W-1:0] test_v;

    always_comb begin
        unique case (tmode_grade_e'(sel))
            GRADE_SHORT: begin
                norm_v = LIM_W'(NORM_B);
                test_v = LIM_W'(TEST_B);
                rel    = LIM_W'(REL_B);
                trst   = LIM_W'(TRST_B);
            end
            GRADE_LONG: begin
                norm_v = LIM_W'(NORM_C);
                test_v = LIM_W'(TEST_C);
                rel    = LIM_W'(REL_C);
                trst   = LIM_W'(TRST_C);
            end
            GRADE_STD, GRADE_ALT: begin
                norm_v = LIM_W'(NORM_A);
                test_v = LIM_W'(TEST_A);
                rel    = LIM_W'(REL_A);
                trst   = LIM_W'(TRST_A);
            end
            default: begin
                norm_v = LIM_W'(NORM_A);
                test_v = LIM_W'(TEST_A);
                rel    = LIM_W'(REL_A);
                trst   = LIM_W'(TRST_A);
            end
        endcase
    end

    assign det = fast ? test_v : norm_v;
endmodule

// File: rtl/tmode_latch.sv
module tmode_latch #(
    parameter int ENTRY_TICKS = 80,
    parameter int LIM_W       = 13,
    parameter int NORM_A      = 4000,
    parameter int NORM_B      = 2000,
    parameter int NORM_C      = 5650,
    parameter int TEST_A      = 64,
    parameter int TEST_B      = 32,
    parameter int TEST_C      = 88,
    parameter int REL_A       = 64,
    parameter int REL_B       = 2,
    parameter int REL_C       = 88,
    parameter int TRST_A      = 12,
    parameter int TRST_B      = 12,
    parameter int TRST_C      = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             req,
    input  logic             det_busy,
    input  logic             det_done,
    input  logic             uvlo,
    input  logic [1:0]       dly_sel,
    output logic             test_mode,
    output logic [LIM_W-1:0] det_limit,
    output logic [LIM_W-1:0] rel_limit,
    output logic [LIM_W-1:0] trst_limit
);
    import tmode_pkg::*;

    tmode_state_e state_q, state_d;
    logic qual;
    logic hold_last;
    logic hold_clr;

    assign qual     = req && !det_busy && !uvlo;
    assign hold_clr = (state_q != ST_ARM) || !qual;

    tmode_hold_cnt #(.ENTRY_TICKS(ENTRY_TICKS)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (hold_clr),
        .adv  (tick),
        .last (hold_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (qual) state_d = ST_ARM;                 // T_ARM
            ST_ARM: begin
                if (!qual)                 state_d = ST_IDLE;    // T_ABORT
                else if (tick && hold_last) state_d = ST_TEST;   // T_ENTER
            end
            ST_TEST: if (det_done) state_d = ST_IDLE;            // T_DONE
            default: state_d = ST_IDLE;
        endcase
        if (uvlo) state_d = ST_IDLE;                             // T_UVLO
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        test_mode = (state_q == ST_TEST);
    end

    tmode_limits #(
        .LIM_W(LIM_W),
        .NORM_A(NORM_A), .NORM_B(NORM_B), .NORM_C(NORM_C),
        .TEST_A(TEST_A), .TEST_B(TEST_B), .TEST_C(TEST_C),
        .REL_A(REL_A),   .REL_B(REL_B),   .REL_C(REL_C),
        .TRST_A(TRST_A), .TRST_B(TRST_B), .TRST_C(TRST_C)
    ) u_lim (
        .sel (dly_sel),
        .fast(test_mode),
        .det (det_limit),
        .rel (rel_limit),
        .trst(trst_limit)
    );
endmodule

// File: rtl/tmode_latch_chk.sv
module tmode_latch_chk #(
    parameter int LIM_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             req,
    input logic             det_busy,
    input logic             det_done,
    input logic             uvlo,
    input logic [1:0]       dly_sel,
    input logic             test_mode,
    input logic [LIM_W-1:0] det_limit,
    input logic [LIM_W-1:0] rel_limit,
    input logic [LIM_W-1:0] trst_limit
);
    a_r2_entry_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> ($past(tick) && $past(req) && !$past(det_busy)));

    a_r4_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !det_done && !uvlo) |=> test_mode);

    a_r7_done_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && det_done) |=> !test_mode);

    a_r8_uvlo_exit: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> !test_mode);

    a_r9_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
        (det_busy && !test_mode) |=> !test_mode);

    a_r10_mode_indep: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(dly_sel) && (test_mode != $past(test_mode)))
            |-> ($stable(rel_limit) && $stable(trst_limit)));

    a_r5_shorter: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(dly_sel) && $rose(test_mode)) |-> (det_limit < $past(det_limit)));
endmodule

bind tmode_latch tmode_latch_chk #(.LIM_W(LIM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(req),
    .det_busy(det_busy), .det_done(det_done), .uvlo(uvlo),
    .dly_sel(dly_sel), .test_mode(test_mode), .det_limit(det_limit),
    .rel_limit(rel_limit), .trst_limit(trst_limit)
);

// File: tb/sim_tmode_latch.sv
module sim_tmode_latch;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 13;
    localparam int ENTRY = 80;

    // {sel, normal det, test det, release, timer reset}
    localparam logic [2+4*LW-1:0] VEC [4] = '{
        {2'd0, 13'd4000, 13'd64, 13'd64, 13'd12},
        {2'd1, 13'd2000, 13'd32, 13'd2,  13'd12},
        {2'd2, 13'd5650, 13'd88, 13'd88, 13'd17},
        {2'd3, 13'd4000, 13'd64, 13'd64, 13'd12}
    };

    logic clk = 0, rst_n = 0, tick = 0, req = 0, det_busy = 0, det_done = 0, uvlo = 0;
    logic [1:0] dly_sel = 0;
    logic test_mode;
    logic [LW-1:0] det_limit, rel_limit, trst_limit;
    int n_chk = 0, n_fail = 0;
    bit ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmode_latch u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .req(req),
        .det_busy(det_busy), .det_done(det_done), .uvlo(uvlo), .dly_sel(dly_sel),
        .test_mode(test_mode), .det_limit(det_limit), .rel_limit(rel_limit),
        .trst_limit(trst_limit));

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1; @(negedge clk);
            tick = 0; @(negedge clk);
        end
    endtask

    task automatic start_hold();
        req = 1; tick = 0; @(negedge clk);
    endtask

    task automatic finish();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        // R1 reset state
        check("R1 test_mode", test_mode, 0);
        check("R1 det_limit", det_limit, 4000);

        // R6 / R10 normal-mode table walk
        for (int i = 0; i < 4; i++) begin
            dly_sel = VEC[i][2+4*LW-1 -: 2]; #1;
            check("R6 det normal", det_limit, VEC[i][4*LW-1 -: LW]);
            check("R10 rel normal", rel_limit, VEC[i][2*LW-1 -: LW]);
            check("R10 trst normal", trst_limit, VEC[i][LW-1:0]);
        end
        dly_sel = 0; @(negedge clk);

        // R2 exact entry boundary
        start_hold();
        ticks(ENTRY - 1);
        check("R2 before last tick", test_mode, 0);
        ticks(1);
        check("R2 entry", test_mode, 1);

        // R4 latched after request removed
        req = 0; repeat (200) @(negedge clk);
        check("R4 latched", test_mode, 1);

        // R5 / R10 test-mode table walk
        for (int i = 0; i < 4; i++) begin
            dly_sel = VEC[i][2+4*LW-1 -: 2]; #1;
            check("R5 det test", det_limit, VEC[i][3*LW-1 -: LW]);
            check("R10 rel test", rel_limit, VEC[i][2*LW-1 -: LW]);
            check("R10 trst test", trst_limit, VEC[i][LW-1:0]);
        end
        dly_sel = 0;

        // R7 detection-done exits, even with request held
        req = 1; det_done = 1; @(negedge clk); det_done = 0;
        check("R7 exit on done", test_mode, 0);
        check("R7 det back to normal", det_limit, 4000);
        tick = 0; @(negedge clk);   // T_ARM edge
        ticks(ENTRY - 1);
        check("R7 re-entry needs full hold", test_mode, 0);
        ticks(1);
        check("R7 re-entry", test_mode, 1);

        // R8 lockout in test
        uvlo = 1; @(negedge clk); uvlo = 0;
        check("R8 uvlo exit", test_mode, 0);
        req = 0; @(negedge clk);

        // R3 drop before completion loses credit
        start_hold();
        ticks(50);
        req = 0; @(negedge clk);
        start_hold();
        ticks(ENTRY - 1);
        check("R3 no partial credit", test_mode, 0);
        ticks(1);
        check("R3 full hold enters", test_mode, 1);
        req = 0; uvlo = 1; @(negedge clk); uvlo = 0;

        // R8 lockout during arming
        start_hold();
        ticks(40);
        uvlo = 1; @(negedge clk); uvlo = 0;
        @(negedge clk);             // T_ARM edge again
        ticks(ENTRY - 1);
        check("R8 arming aborted", test_mode, 0);
        ticks(1);
        check("R8 entry after lockout", test_mode, 1);
        req = 0; uvlo = 1; @(negedge clk); uvlo = 0;

        // R9 busy blocks entry
        det_busy = 1; req = 1; @(negedge clk);
        ticks(ENTRY + 20);
        check("R9 busy ignores request", test_mode, 0);
        det_busy = 0; @(negedge clk);
        ticks(30);
        det_busy = 1; @(negedge clk); det_busy = 0;
        @(negedge clk);
        ticks(ENTRY - 1);
        check("R9 busy aborts arming", test_mode, 0);
        ticks(1);
        check("R9 entry after busy", test_mode, 1);

        // R1 reset clears latched mode
        rst_n = 0; req = 0; @(negedge clk); rst_n = 1; @(negedge clk);
        check("R1 reset clears", test_mode, 0);

        finish();
    end
endmodule